// File: doc/BRIEF.md
# Staggered Counter Deskew Bank

A counter whose carry is pipelined one register per stage delivers its bits late: bit k (numbered from 1 at the least significant end) toggles k-1 clock cycles after it would in an ordinary binary counter. This bank sits on those raw bits. It passes each bit through its own shift register, so that all bits line up and the output reads as a plain binary count. The output lags the true count by a fixed number of cycles, and the consumer needs no decoding step.

A bit of weight 2^(k-1) repeats with period 2^k while the counter runs free. Its alignment delay n-k can therefore be cut to (n-k) mod 2^k cycles without changing what the bit shows. This keeps the long delay lines short for the upper bits, and the top bit needs no register at all. Counting may pause only through one shared advance enable. That enable must gate the source counter and every delay register in the same cycle, so the modular reduction stays valid.

Top module: `deskew_bank`

## Requirements
- R1: A synchronous reset clears every delay register, so each output bit that has a nonzero delay reads 0 on the cycle after reset is sampled high.
- R2: With bits numbered k = 1..n from the LSB (port bit index k-1), output bit k equals the raw bit k as sampled (n-k) mod 2^k advancing clock edges earlier, or 0 if fewer such edges have occurred since reset. For n = 16 the delays are 1, 2, 5, 12, 11, 10, ... 1, 0; for n = 5 they are 0, 3, 2, 1, 0.
- R3: A bit whose delay is zero is a direct path: the output bit follows the raw bit in the same cycle, whether advance is high or low.
- R4: When the input comes from a staggered counter (stage k toggles k-1 cycles behind binary, gated by the same advance), the output rises by exactly 1 on each advancing edge once the output has settled.
- R5: In that use, once A ≥ n-1, where A is the number of advancing edges since reset, the output equals (A - (n-1)) mod 2^n.
- R6: While advance is low, no delay register changes, so every registered output bit holds whatever the raw inputs do.
- R7: The aligned output wraps from all ones to zero and then continues counting by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Shared advance enable, also driving the source counter |
| raw_bits | input | WIDTH | Raw staggered counter bits, LSB at index 0 |
| bin_count | output | WIDTH | Aligned binary count |

## Verification
The bench builds two copies. One has WIDTH = 16, where the LSB carries a one-cycle delay, the longest tap is 12 and only the top bit is a wire. The other has WIDTH = 5, where both the LSB and the MSB are wires and the taps run 3, 2, 1. The wide copy is driven long enough to wrap through all 65536 states while the advance enable is dropped at random. The narrow copy wraps thousands of times in the same run and exposes the same-cycle path on its lowest bit. Both copies also receive random raw patterns, checked against a per-bit history model.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    // Delay for bit k (1-based from LSB) of an n-bit staggered counter
    function automatic int lag_of(input int width, input int k);
        int span;
        span = width - k;
        if (k >= 31) begin
            return span;
        end
        return span % (1 << k);
    endfunction

    // Largest per-bit delay of the bank
    function automatic int max_lag(input int width);
        int m;
        m = 0;
        for (int k = 1; k <= width; k++) begin
            if (lag_of(width, k) > m) begin
                m = lag_of(width, k);
            end
        end
        return m;
    endfunction

    // Mask of output bits that pass through at least one register
    function automatic logic [63:0] reg_mask(input int width);
        logic [63:0] m;
        m = '0;
        for (int k = 1; k <= width; k++) begin
            if (lag_of(width, k) > 0) begin
                m[k-1] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/deskew_cell.sv
module deskew_cell (
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (step_en) begin
            q <= d;
        end
    end

    AST_CELL_LOAD: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (q == $past(d))); // R2

    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(q)); // R6

    AST_CELL_CLEAR: assert property (@(posedge clk)
        rst |=> (q == 1'b0)); // R1

endmodule

// File: rtl/deskew_tap.sv
module deskew_tap #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  logic din,
    output logic dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_chain
            logic [DEPTH:0] link;
            assign link[0] = din;
            for (genvar i = 0; i < DEPTH; i++) begin : g_cell
                deskew_cell u_cell (
                    .clk     (clk),
                    .rst     (rst),
                    .step_en (step_en),
                    .d       (link[i]),
                    .q       (link[i+1])
                );
            end
            assign dout = link[DEPTH];
        end
    endgenerate

endmodule

// File: rtl/deskew_bank.sv
module deskew_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic [WIDTH-1:0] raw_bits,
    output logic [WIDTH-1:0] bin_count
);
    import deskew_pkg::*;

    localparam int               LONGEST  = max_lag(WIDTH);
    localparam logic [WIDTH-1:0] REG_MASK = WIDTH'(reg_mask(WIDTH));

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            deskew_tap #(
                .DEPTH (lag_of(WIDTH, b + 1))
            ) u_tap (
                .clk     (clk),
                .rst     (rst),
                .step_en (step_en),
                .din     (raw_bits[b]),
                .dout    (bin_count[b])
            );
        end
    endgenerate

    initial begin
        assert (LONGEST < WIDTH);
    end

    AST_BANK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> (((bin_count ^ $past(bin_count)) & REG_MASK) == '0)); // R6

endmodule

// File: tb/sim_deskew_bank.sv
`timescale 1ns/1ps
module sim_deskew_bank;
    localparam int NA = 16;
    localparam int NB = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0;
    logic [NA-1:0] raw0 = '0;
    logic [NB-1:0] raw1 = '0;
    logic [NA-1:0] count0;
    logic [NB-1:0] count1;

    int errors = 0;
    int checks = 0;
    int adv_n = 0;
    logic [15:0] hist0 [256];
    logic [15:0] hist1 [256];
    logic [15:0] last0, last1;
    int last_adv;
    logic [15:0] sq0, sp0, sq1, sp1;

    always #4 clk = ~clk;

    deskew_bank #(.WIDTH(NA)) u0 (
        .clk(clk), .rst(rst), .step_en(step_en), .raw_bits(raw0), .bin_count(count0));
    deskew_bank #(.WIDTH(NB)) u1 (
        .clk(clk), .rst(rst), .step_en(step_en), .raw_bits(raw1), .bin_count(count1));

    function automatic int lagb(input int n, input int k);
        return (n - k) % (1 << k);
    endfunction

    function automatic logic [15:0] mask_of(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    function automatic logic [15:0] model_out(input int inst, input int n, input logic [15:0] cur);
        logic [15:0] e;
        int d;
        e = '0;
        for (int b = 0; b < n; b++) begin
            d = lagb(n, b + 1);
            if (d == 0) e[b] = cur[b];
            else if (adv_n >= d) e[b] = (inst == 0) ? hist0[(adv_n - d + 1) % 256][b]
                                                     : hist1[(adv_n - d + 1) % 256][b];
        end
        return e;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (adv=%0d)", tag, act, exp, adv_n);
        end
    endtask

    task automatic stag_adv(inout logic [15:0] q, inout logic [15:0] p, input int n);
        logic [15:0] oq, op;
        logic en;
        oq = q; op = p;
        for (int k = 0; k < n; k++) begin
            en = (k == 0) ? 1'b1 : op[k-1];
            p[k] = en & oq[k];
            q[k] = oq[k] ^ en;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step_en = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0; adv_n = 0; last_adv = -1;
        sq0 = '0; sp0 = '0; sq1 = '0; sp1 = '0;
    endtask

    // One cycle: drive, compare before the edge, update model at the edge
    task automatic cyc(input logic a, input logic [15:0] r0, input logic [15:0] r1, input logic stag);
        logic [15:0] e0, e1;
        @(negedge clk);
        step_en = a; raw0 = r0[NA-1:0]; raw1 = r1[NB-1:0];
        #1;
        check("R2 n16", {{(16-NA){1'b0}}, count0}, model_out(0, NA, r0));
        check("R2 n5", {11'b0, count1}, model_out(1, NB, r1 & mask_of(NB)));
        if (stag && adv_n >= NA - 1) begin
            e0 = 16'(adv_n - (NA - 1)) & mask_of(NA);
            check((e0 == 0 && adv_n > NA - 1) ? "R7 n16" : "R5 n16", count0, e0);
            if (last_adv == adv_n - 1 && adv_n > NA - 1)
                check("R4 n16", count0, (last0 + 16'd1) & mask_of(NA));
        end
        if (stag && adv_n >= NB - 1) begin
            e1 = 16'(adv_n - (NB - 1)) & mask_of(NB);
            check((e1 == 0 && adv_n > NB - 1) ? "R7 n5" : "R5 n5", {11'b0, count1}, e1);
            if (last_adv == adv_n - 1 && adv_n > NB - 1)
                check("R4 n5", {11'b0, count1}, (last1 + 16'd1) & mask_of(NB));
        end
        last0 = {{(16-NA){1'b0}}, count0}; last1 = {11'b0, count1}; last_adv = adv_n;
        @(posedge clk);
        if (a) begin
            adv_n++;
            hist0[adv_n % 256] = r0;
            hist1[adv_n % 256] = r1 & mask_of(NB);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] snap0, snap1;
        void'($urandom(32'd1234));
        do_reset();
        #1;
        check("R1 n16", {{(16-NA){1'b0}}, count0}, 16'h0);
        check("R1 n5", {11'b0, count1}, 16'h0);

        // R2 impulse: all ones for one advancing edge, then zeros
        cyc(1'b1, 16'hffff, 16'h001f, 1'b0);
        for (int i = 0; i < 16; i++) cyc(1'b1, 16'h0, 16'h0, 1'b0);

        // R3: zero-delay bits follow raw in the same cycle, even when paused
        @(negedge clk); step_en = 1'b0; raw1 = 5'b00001; raw0 = 16'h8000; #1;
        check("R3 n5 lsb", {15'b0, count1[0]}, 16'h1);
        check("R3 n16 msb", {15'b0, count0[NA-1]}, 16'h1);
        raw1 = 5'b00000; raw0 = 16'h0; #1;
        check("R3 n5 lsb low", {15'b0, count1[0]}, 16'h0);

        // Random raw patterns and random advance
        for (int i = 0; i < 400; i++)
            cyc(($urandom % 4) != 0, 16'($urandom), 16'($urandom), 1'b0);

        // R6: paused bank ignores raw changes on registered bits
        @(negedge clk); step_en = 1'b0; #1;
        snap0 = {{(16-NA){1'b0}}, count0}; snap1 = {11'b0, count1};
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); raw0 = 16'($urandom); raw1 = 5'($urandom); #1;
            check("R6 n16", {{(16-NA){1'b0}}, count0} & 16'h7fff, snap0 & 16'h7fff);
            check("R6 n5", {11'b0, count1} & 16'h000e, snap1 & 16'h000e);
        end

        // R1: reset in mid-run clears registered bits
        @(negedge clk); rst = 1'b1; raw0 = 16'hffff; raw1 = 5'h1f;
        @(posedge clk); @(negedge clk); #1;
        check("R1 n16 mid", {{(16-NA){1'b0}}, count0} & 16'h7fff, 16'h0);
        check("R1 n5 mid", {11'b0, count1} & 16'h000e, 16'h0);

        // Staggered counter source, long enough to wrap the 16-bit copy
        do_reset();
        for (int i = 0; i < 70000; i++) begin
            logic a;
            a = ($urandom % 16) != 0;
            cyc(a, sq0, sq1, 1'b1);
            if (a) begin
                stag_adv(sq0, sp0, NA);
                stag_adv(sq1, sp1, NB);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule